// File: doc/BRIEF.md
# Eight-Bit GPIO Port with Direction-Gated Pullups

This block is one byte-wide general-purpose I/O port that sits on a simple register bus. Every pin has three control bits: an output latch bit, a direction bit and a pullup enable bit. Each bit lives in its own byte register. The block drives three control signals into each external pad cell: output enable, output value and pullup request. It also samples the pad input levels through a synchronizer.

A read of the data register returns a different source per bit. A pin set as output reads back its latch bit. A pin set as input reads back its synchronized pad level. Software may write the latch at any time, and the stored value appears on the pad once the pin is turned into an output. A pin's pullup request is active only while that pin is an input. Turning a pin into an output drops its pullup at once, and the stored enable bit is kept. With the enable bit clear, an input pin is left at high impedance. With it set, the pad pulls the pin up to the supply.

Top module: `gpio_pullup_port`

## Requirements
- R1: A synchronous active-high reset clears the latch, direction and pullup registers and the input synchronizer. After reset, pad_oe, pad_do and pad_pu are all 0x00, and reads of offsets 0x3, 0x7 and 0xF return 0x00.
- R2: A bus write to offset 0x3 loads the output latch on that clock edge, whatever the direction bits are. pad_do equals the latch from the cycle after the write.
- R3: A read of offset 0x3 returns, for each bit, the latch bit when the direction bit is 1 and the synchronized pin level when it is 0.
- R4: A change on pin_in becomes visible in a read of an input bit at offset 0x3 after exactly two rising clock edges. After one edge the old level is still returned.
- R5: pad_oe bit i equals direction bit i. A value of 1 means the pin is an output.
- R6: pad_pu bit i is 1 only when pullup bit i is 1 and direction bit i is 0. Setting a direction bit to 1 clears the matching pad_pu bit in the cycle after the write. The stored pullup bit is unchanged and still reads back at offset 0xF.
- R7: A write to offset 0x3 while a pin is an input leaves pad_oe for that pin at 0. After the write, a read of that bit still returns the pin level.
- R8: The direction register at offset 0x7 and the pullup register at offset 0xF each store all eight bits written and return them on read.
- R9: A read of any offset other than 0x3, 0x7 or 0xF returns 0x00. A write to such an offset changes no register.
- R10: A register is written only in a cycle where cs and we are both 1. With either one at 0, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select for the bus access |
| we | input | 1 | Write strobe; a write happens when cs and we are both 1 |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the addressed register |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pad_oe | output | 8 | Per-pin output enable |
| pad_do | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pullup request, gated by direction |

## Verification
The bench builds the block with its default parameters. These are eight pins, a four-bit offset, a two-stage synchronizer and the offsets 0x3, 0x7 and 0xF. With a two-stage synchronizer, the bench can check the exact edge at which a pin change first appears in a read. With a four-bit offset, every unmapped offset is reachable. Mixed direction patterns such as 0x0F and 0xF0 split every read of offset 0x3 between latch bits and pin bits. The same patterns split the pullup gating within one byte.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int DEF_PORT_W = 8;
    localparam int DEF_ADDR_W = 4;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_PULL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic data;
        logic dir;
        logic pull;
    } wr_strobe_t;

    function automatic wr_strobe_t strobe_for(reg_sel_e sel, logic wr_en);
        wr_strobe_t s;
        s.data = wr_en && (sel == SEL_DATA);
        s.dir  = wr_en && (sel == SEL_DIR);
        s.pull = wr_en && (sel == SEL_PULL);
        return s;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'h3,
    parameter logic [ADDR_W-1:0] DIR_OFS  = 'h7,
    parameter logic [ADDR_W-1:0] PULL_OFS = 'hF
) (
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output wr_strobe_t        wr
);

    always_comb begin
        sel = SEL_NONE;
        if (cs) begin
            if (addr == DATA_OFS)      sel = SEL_DATA;
            else if (addr == DIR_OFS)  sel = SEL_DIR;
            else if (addr == PULL_OFS) sel = SEL_PULL;
        end
    end

    assign wr = strobe_for(sel, cs && we);

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_port_pkg::*;
#(
    parameter int PORT_W = DEF_PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_strobe_t        wr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] pull_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
            pull_q  <= '0;
        end else begin
            if (wr.data) latch_q <= wdata;
            if (wr.dir)  dir_q   <= wdata;
            if (wr.pull) pull_q  <= wdata;
        end
    end

    // R1: the cycle after reset all control registers are clear
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (latch_q == '0 && dir_q == '0 && pull_q == '0));

    // R2: a data write lands in the latch on the next edge
    p_latch_load_r2: assert property (@(posedge clk) disable iff (rst)
        wr.data |=> latch_q == $past(wdata));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_port_pkg::*;
#(
    parameter int PORT_W = DEF_PORT_W,
    parameter int STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_s
);

    logic [PORT_W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else if (g == 0) stage_q[g] <= pin_in;
                else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign pin_s = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_port_pkg::*;
#(
    parameter int PORT_W = DEF_PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] latch_q,
    input  logic [PORT_W-1:0] dir_q,
    input  logic [PORT_W-1:0] pull_q,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_do,
    output logic [PORT_W-1:0] pad_pu
);

    genvar i;
    generate
        for (i = 0; i < PORT_W; i++) begin : g_pin
            assign pad_oe[i] = dir_q[i];
            assign pad_do[i] = latch_q[i];
            assign pad_pu[i] = pull_q[i] & ~dir_q[i];

            // R6: a driven pin never has its pullup engaged
            p_pull_gated_r6: assert property (@(posedge clk) disable iff (rst)
                pad_oe[i] |-> !pad_pu[i]);
        end
    endgenerate

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int PORT_W = DEF_PORT_W
) (
    input  reg_sel_e          sel,
    input  logic [PORT_W-1:0] latch_q,
    input  logic [PORT_W-1:0] dir_q,
    input  logic [PORT_W-1:0] pull_q,
    input  logic [PORT_W-1:0] pin_s,
    output logic [PORT_W-1:0] rdata
);

    logic [PORT_W-1:0] data_view;

    genvar i;
    generate
        for (i = 0; i < PORT_W; i++) begin : g_bit
            assign data_view[i] = dir_q[i] ? latch_q[i] : pin_s[i];
        end
    endgenerate

    always_comb begin
        case (sel)
            SEL_DATA: rdata = data_view;
            SEL_DIR:  rdata = dir_q;
            SEL_PULL: rdata = pull_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pullup_port.sv
module gpio_pullup_port
    import gpio_port_pkg::*;
#(
    parameter int PORT_W      = DEF_PORT_W,
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'h3,
    parameter logic [ADDR_W-1:0] DIR_OFS  = 'h7,
    parameter logic [ADDR_W-1:0] PULL_OFS = 'hF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_do,
    output logic [PORT_W-1:0] pad_pu
);

    reg_sel_e          sel;
    wr_strobe_t        wr;
    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] pull_q;
    logic [PORT_W-1:0] pin_s;

    gpio_addr_decode #(
        .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS), .PULL_OFS(PULL_OFS)
    ) u_dec (
        .cs(cs), .we(we), .addr(addr), .sel(sel), .wr(wr)
    );

    gpio_ctrl_regs #(.PORT_W(PORT_W)) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .wdata(wdata),
        .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q)
    );

    gpio_in_sync #(.PORT_W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_s(pin_s)
    );

    gpio_pad_ctrl #(.PORT_W(PORT_W)) u_pad (
        .clk(clk), .rst(rst), .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q),
        .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu)
    );

    gpio_read_mux #(.PORT_W(PORT_W)) u_rmux (
        .sel(sel), .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q),
        .pin_s(pin_s), .rdata(rdata)
    );

    logic unmapped;
    assign unmapped = (addr != DATA_OFS) && (addr != DIR_OFS) && (addr != PULL_OFS);

    // R9: a write to an unused offset changes nothing visible
    p_unmapped_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (cs && we && unmapped) |=> ($stable(pad_oe) && $stable(pad_do) && $stable(pull_q)));

    // R10: without both strobes the registers hold
    p_no_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !(cs && we) |=> ($stable(pad_oe) && $stable(pad_do) && $stable(pull_q)));

    // R3: output bits of a data read agree with what the pads drive
    p_read_latch_r3: assert property (@(posedge clk) disable iff (rst)
        (cs && addr == DATA_OFS) |-> ((rdata & pad_oe) == (pad_do & pad_oe)));

    // R8: direction readback agrees with the pad output enables
    p_dir_read_r8: assert property (@(posedge clk) disable iff (rst)
        (cs && addr == DIR_OFS) |-> (rdata == pad_oe));

    generate
        if (SYNC_STAGES == 2) begin : g_lat_chk
            // R4: input bits show the pin level from two edges earlier
            p_input_latency_r4: assert property (@(posedge clk) disable iff (rst)
                (cs && addr == DATA_OFS && !$past(rst) && !$past(rst, 2))
                |-> ((rdata & ~pad_oe) == ($past(pin_in, 2) & ~pad_oe)));
        end
    endgenerate

endmodule

// File: tb/gpio_pullup_port_test.sv
`timescale 1ns/1ps
module gpio_pullup_port_test;

    localparam logic [2:0] OP_WR  = 3'd0;
    localparam logic [2:0] OP_RD  = 3'd1;
    localparam logic [2:0] OP_PIN = 3'd2;
    localparam logic [2:0] OP_OE  = 3'd3;
    localparam logic [2:0] OP_PU  = 3'd4;
    localparam logic [2:0] OP_DO  = 3'd5;

    typedef struct packed {
        logic [2:0] op;
        logic [3:0] addr;
        logic [7:0] data;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 40;
    localparam vec_t VEC [NVEC] = '{
        '{OP_RD,  4'h3, 8'h00, 4'd1},   // R1 data read after reset
        '{OP_RD,  4'h7, 8'h00, 4'd1},   // R1
        '{OP_RD,  4'hF, 8'h00, 4'd1},   // R1
        '{OP_OE,  4'h0, 8'h00, 4'd1},   // R1
        '{OP_PU,  4'h0, 8'h00, 4'd1},   // R1
        '{OP_DO,  4'h0, 8'h00, 4'd1},   // R1
        '{OP_WR,  4'hF, 8'hA5, 4'd8},
        '{OP_PU,  4'h0, 8'hA5, 4'd6},   // R6 all inputs: pullups pass
        '{OP_RD,  4'hF, 8'hA5, 4'd8},   // R8
        '{OP_WR,  4'h7, 8'h0F, 4'd5},
        '{OP_OE,  4'h0, 8'h0F, 4'd5},   // R5
        '{OP_PU,  4'h0, 8'hA0, 4'd6},   // R6 low nibble gated off
        '{OP_RD,  4'h7, 8'h0F, 4'd8},   // R8
        '{OP_RD,  4'hF, 8'hA5, 4'd6},   // R6 stored bits kept
        '{OP_WR,  4'h3, 8'h3C, 4'd2},
        '{OP_DO,  4'h0, 8'h3C, 4'd2},   // R2
        '{OP_PIN, 4'h0, 8'hC3, 4'd3},
        '{OP_RD,  4'h3, 8'hCC, 4'd3},   // R3 low latch, high pin
        '{OP_WR,  4'h7, 8'hF0, 4'd3},
        '{OP_RD,  4'h3, 8'h33, 4'd3},   // R3 high latch, low pin
        '{OP_PU,  4'h0, 8'h05, 4'd6},   // R6
        '{OP_WR,  4'h7, 8'h00, 4'd7},
        '{OP_PIN, 4'h0, 8'h5A, 4'd3},
        '{OP_RD,  4'h3, 8'h5A, 4'd3},   // R3 all pin
        '{OP_OE,  4'h0, 8'h00, 4'd7},   // R7
        '{OP_WR,  4'h3, 8'hFF, 4'd7},
        '{OP_OE,  4'h0, 8'h00, 4'd7},   // R7 write did not drive
        '{OP_DO,  4'h0, 8'hFF, 4'd2},   // R2 latch written while input
        '{OP_RD,  4'h3, 8'h5A, 4'd7},   // R7 read still shows pin
        '{OP_WR,  4'h7, 8'hFF, 4'd2},
        '{OP_RD,  4'h3, 8'hFF, 4'd2},   // R2 latch kept
        '{OP_PU,  4'h0, 8'h00, 4'd6},   // R6 all outputs
        '{OP_WR,  4'h0, 8'h12, 4'd9},
        '{OP_WR,  4'h5, 8'h34, 4'd9},
        '{OP_RD,  4'h0, 8'h00, 4'd9},   // R9
        '{OP_RD,  4'h5, 8'h00, 4'd9},   // R9
        '{OP_RD,  4'h7, 8'hFF, 4'd9},   // R9
        '{OP_RD,  4'hF, 8'hA5, 4'd9},   // R9
        '{OP_DO,  4'h0, 8'hFF, 4'd9},   // R9
        '{OP_RD,  4'h3, 8'hFF, 4'd9}    // R9
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0;
    logic       we = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] pin_in = '0;
    logic [7:0] rdata, pad_oe, pad_do, pad_pu;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_pullup_port uut (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu)
    );

    task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        cs = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            case (VEC[k].op)
                OP_WR: bus_write(VEC[k].addr, VEC[k].data);
                OP_RD: begin
                    bus_read(VEC[k].addr, rv);
                    check(int'(VEC[k].req), $sformatf("vec %0d read", k), rv, VEC[k].data);
                end
                OP_PIN: begin
                    @(negedge clk);
                    pin_in = VEC[k].data;
                    repeat (3) @(negedge clk);
                end
                OP_OE: begin
                    @(negedge clk); #1;
                    check(int'(VEC[k].req), $sformatf("vec %0d pad_oe", k), pad_oe, VEC[k].data);
                end
                OP_PU: begin
                    @(negedge clk); #1;
                    check(int'(VEC[k].req), $sformatf("vec %0d pad_pu", k), pad_pu, VEC[k].data);
                end
                default: begin
                    @(negedge clk); #1;
                    check(int'(VEC[k].req), $sformatf("vec %0d pad_do", k), pad_do, VEC[k].data);
                end
            endcase
        end

        // R10: write with cs low, then with we low
        @(negedge clk);
        cs = 1'b0; we = 1'b1; addr = 4'h7; wdata = 8'h00;
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = 4'h3; wdata = 8'h00;
        @(negedge clk);
        cs = 1'b0;
        bus_read(4'h7, rv);
        check(10, "dir after unstrobed write", rv, 8'hFF);
        #1 check(10, "pad_do after unstrobed write", pad_do, 8'hFF);

        // R4: edge-exact input latency
        bus_write(4'h7, 8'h00);
        @(negedge clk);
        pin_in = 8'h81;
        cs = 1'b1; addr = 4'h3;
        #1 check(4, "latency 0 edges", rdata, 8'h5A);
        @(negedge clk); #1;
        check(4, "latency 1 edge", rdata, 8'h5A);
        @(negedge clk); #1;
        check(4, "latency 2 edges", rdata, 8'h81);
        cs = 1'b0;

        // R1: reset in the middle of operation
        bus_write(4'h7, 8'h3C);
        bus_write(4'hF, 8'hFF);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 check(1, "pad_oe after reset", pad_oe, 8'h00);
        check(1, "pad_pu after reset", pad_pu, 8'h00);
        check(1, "pad_do after reset", pad_do, 8'h00);
        bus_read(4'hF, rv);
        check(1, "pullup reg after reset", rv, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule